// File: doc/BRIEF.md
# Slave-Serial Configuration Sequencer

This block loads a configuration bitstream into an SRAM-based programmable device through the device's slave-serial port. It acts as the timing master for the whole load. It first pulls the device's active-low reset strobe low. It then waits for the device's initialization line to follow the strobe down and back up. Only after that does it generate the configuration clock and shift the bitstream out, one bit per clock. When the stream ends, it keeps clocking for a bounded window while it waits for the completion flag.

Bitstream bytes come in on a byte stream with valid/ready handshaking, and the last byte is tagged. A single start pulse launches the sequence. When the sequence ends, exactly one of three sticky result flags is set: success, CRC error or timeout. The flag stays set until the next accepted start. The configuration clock comes from a divided system clock. It is parked low whenever no byte is held, so a slow producer stalls the link cleanly. The initialization and completion inputs pass through a synchronizer before the sequencer uses them.

Top module: `ssc_loader`

## Requirements
- R1: After an accepted start, `prog_b_o` goes low and stays low for at least `PROG_LOW_CYC` system clocks. It is released only once `init_b_i` has been seen low.
- R2: After release, no rising edge appears on `cclk_o` until `init_b_i` has been seen high. If `init_b_i` stays low for `INIT_TMO_CYC` clocks after release, the sequence ends with `timeout_o` set and no clock edge issued.
- R3: Every accepted byte is sent as 8 consecutive configuration-clock rising edges, most significant bit first. Bytes are sent in acceptance order.
- R4: `din_o` does not change while `cclk_o` is high. It changes only in the low phase, so the value is settled at each rising edge.
- R5: While running, `cclk_o` has a period of `CCLK_DIV` system clocks and a high time of `CCLK_DIV/2` system clocks.
- R6: When no byte is held during the data phase, `cclk_o` stays low and `cfg_ready_o` is high. `cfg_ready_o` is high only in the data phase, and only when the holding register is empty.
- R7: After the last bit of the tagged last byte, `done_i` going high ends the sequence with `ok_o` set and `busy_o` low.
- R8: Once the data phase has begun, a low level on `init_b_i` stops the clock and ends the sequence with `crc_err_o` set.
- R9: After the last byte, the block issues up to `DONE_EXTRA` further clock cycles with `din_o` high. If `done_i` is not seen within them, the sequence ends with `timeout_o` set after exactly that many extra rising edges.
- R10: A start pulse while `busy_o` is high has no effect: `prog_b_o` does not pulse again and the running load completes normally.
- R11: `busy_o` is high from the cycle after an accepted start until the sequence ends. At most one result flag is set at a time. All result flags clear on an accepted start and otherwise hold their value.
- R12: After reset, `prog_b_o` is high, `cclk_o` and `cfg_ready_o` are low, and `busy_o`, `ok_o`, `crc_err_o` and `timeout_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; honoured only when idle |
| cfg_data_i | input | 8 | Bitstream byte |
| cfg_valid_i | input | 1 | Byte is valid |
| cfg_last_i | input | 1 | Byte is the final one of the stream |
| cfg_ready_o | output | 1 | Block accepts a byte this cycle |
| prog_b_o | output | 1 | Active-low reset strobe to the target |
| init_b_i | input | 1 | Target initialization / CRC status line |
| cclk_o | output | 1 | Configuration clock to the target |
| din_o | output | 1 | Serial configuration data |
| done_i | input | 1 | Target completion flag |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | Sticky: completed successfully |
| crc_err_o | output | 1 | Sticky: target reported CRC error |
| timeout_o | output | 1 | Sticky: init or done wait expired |

## Verification
The bench uses a behavioural target that answers the reset strobe, samples `din_o` on each clock rise and drives completion or error. Random byte values with random producer gaps, fed as a stream, test ordering and bit order. Long gaps show that the clock stalls instead of sending stale bits. A directed stream of 0x00, 0xFF, 0x80, 0x01, 0xAA and 0x55 catches bit-order reversal and bit-stuck faults that random data might miss. Four target behaviours are run so that each ending is reached: completion, CRC error after a chosen bit count, initialization never released, and completion never raised. Separate rise counts and flags tell these endings apart, and a start poked mid-load checks that it is ignored.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PROG = 3'd1,
    ST_INIT = 3'd2,
    ST_DATA = 3'd3,
    ST_POST = 3'd4
  } ssc_state_e;

  // configuration clock level for a divider phase: low half first, then high
  function automatic logic cclk_level(input int unsigned phase, input int unsigned div);
    return phase >= (div / 2);
  endfunction

  // a zero-based counter has reached the last cycle of a window of 'limit'
  function automatic logic window_end(input int unsigned cnt, input int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction

endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/ssc_serializer.sv
module ssc_serializer
  import ssc_pkg::*;
#(
  parameter int DIV   = 4,
  parameter int EXTRA = 6,
  parameter int BW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_en,
  input  logic          post_en,
  input  logic [BW-1:0] byte_data,
  input  logic          byte_valid,
  input  logic          byte_last,
  output logic          byte_ready,
  output logic          cclk,
  output logic          din,
  output logic          last_bit_done,
  output logic          post_expired
);

  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int CW = $clog2(BW);
  localparam int EW = $clog2(EXTRA + 1);

  logic          have_q;
  logic          last_q;
  logic [BW-1:0] sh_q;
  logic [CW-1:0] bit_q;
  logic [PW-1:0] phase_q;
  logic [EW-1:0] extra_q;

  // named events for the sequencer and the assertions
  logic running;
  logic period_end;
  logic take;
  logic byte_end;

  assign running    = (data_en && have_q) || post_en;
  assign period_end = running && (phase_q == PW'(DIV - 1));
  assign byte_ready = data_en && !have_q;
  assign take       = byte_ready && byte_valid;
  assign byte_end   = data_en && period_end && (bit_q == CW'(BW - 1));

  assign last_bit_done = byte_end && last_q;
  assign post_expired  = post_en && period_end && window_end(32'(extra_q), EXTRA);
  assign cclk          = running && cclk_level(32'(phase_q), DIV);
  assign din           = post_en ? 1'b1 : sh_q[BW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!running || period_end) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      last_q <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
    end else if (!data_en) begin
      have_q <= 1'b0;
    end else if (take) begin
      have_q <= 1'b1;
      last_q <= byte_last;
      sh_q   <= byte_data;
      bit_q  <= '0;
    end else if (byte_end) begin
      have_q <= 1'b0;
    end else if (period_end) begin
      sh_q  <= {sh_q[BW-2:0], 1'b0};
      bit_q <= bit_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          extra_q <= '0;
    else if (!post_en)   extra_q <= '0;
    else if (period_end) extra_q <= extra_q + EW'(1);
  end

  AST_DIN_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk && $past(cclk)) |-> $stable(din)); // R4

  AST_CCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && !have_q) |-> !cclk); // R6

  AST_NO_LOAD_MIDBYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (have_q && !byte_end && data_en) |=> $stable(sh_q) || $past(period_end)); // R3

endmodule

// File: rtl/ssc_ctrl.sv
module ssc_ctrl
  import ssc_pkg::*;
#(
  parameter int PROG_LOW = 8,
  parameter int INIT_TMO = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic init_s,
  input  logic done_s,
  input  logic last_bit_done,
  input  logic post_expired,
  output logic prog_b,
  output logic data_en,
  output logic post_en,
  output logic busy,
  output logic ok,
  output logic crc_err,
  output logic timeout
);

  localparam int TMAX = (PROG_LOW > INIT_TMO) ? PROG_LOW : INIT_TMO;
  localparam int TW   = $clog2(TMAX + 1);

  ssc_state_e  state_q;
  logic [TW-1:0] tmr_q;
  logic [TW-1:0] lowlen_q;
  logic ok_q, crc_q, tmo_q;

  // named events
  logic pulse_met;
  logic init_expired;
  logic crc_hit;

  assign pulse_met    = window_end(32'(tmr_q), PROG_LOW);
  assign init_expired = window_end(32'(tmr_q), INIT_TMO);
  assign crc_hit      = ((state_q == ST_DATA) || (state_q == ST_POST)) && !init_s;

  assign prog_b  = (state_q != ST_PROG);
  assign data_en = (state_q == ST_DATA);
  assign post_en = (state_q == ST_POST);
  assign busy    = (state_q != ST_IDLE);
  assign ok      = ok_q;
  assign crc_err = crc_q;
  assign timeout = tmo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      ok_q    <= 1'b0;
      crc_q   <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_PROG;
            tmr_q   <= '0;
            ok_q    <= 1'b0;
            crc_q   <= 1'b0;
            tmo_q   <= 1'b0;
          end
        end
        ST_PROG: begin
          if (pulse_met && !init_s) begin
            state_q <= ST_INIT;
            tmr_q   <= '0;
          end else if (init_expired) begin
            tmo_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            tmr_q <= tmr_q + TW'(1);
          end
        end
        ST_INIT: begin
          if (init_s) begin
            state_q <= ST_DATA;
          end else if (init_expired) begin
            tmo_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            tmr_q <= tmr_q + TW'(1);
          end
        end
        ST_DATA: begin
          if (crc_hit) begin
            crc_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (last_bit_done) begin
            state_q <= ST_POST;
          end
        end
        ST_POST: begin
          if (crc_hit) begin
            crc_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (done_s) begin
            ok_q    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (post_expired) begin
            tmo_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // length of the current reset strobe, kept for the pulse-width check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   lowlen_q <= '0;
    else if (state_q != ST_PROG)                  lowlen_q <= '0;
    else if (lowlen_q != TW'(PROG_LOW))           lowlen_q <= lowlen_q + TW'(1);
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_b) |-> ($past(lowlen_q) >= TW'(PROG_LOW - 1))); // R1

  AST_STROBE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_b) |-> ($past(state_q) == ST_IDLE)); // R10

  AST_CRC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    crc_hit |=> (crc_err && !busy)); // R8

  AST_DONE_OK: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_POST) && init_s && done_s) |=> (ok && !busy)); // R7

  AST_INIT_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_INIT) && !init_s && init_expired) |=> (timeout && !data_en)); // R2

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ok, crc_err, timeout})); // R11

endmodule

// File: rtl/ssc_loader.sv
module ssc_loader #(
  parameter int CCLK_DIV     = 4,
  parameter int PROG_LOW_CYC = 8,
  parameter int INIT_TMO_CYC = 40,
  parameter int DONE_EXTRA   = 6,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] cfg_data_i,
  input  logic       cfg_valid_i,
  input  logic       cfg_last_i,
  output logic       cfg_ready_o,
  output logic       prog_b_o,
  input  logic       init_b_i,
  output logic       cclk_o,
  output logic       din_o,
  input  logic       done_i,
  output logic       busy_o,
  output logic       ok_o,
  output logic       crc_err_o,
  output logic       timeout_o
);

  localparam int BYTE_W = 8;

  logic init_s, done_s;
  logic data_en, post_en;
  logic last_bit_done, post_expired;

  ssc_sync #(
    .W      (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b01)
  ) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({done_i, init_b_i}),
    .q    ({done_s, init_s})
  );

  ssc_ctrl #(
    .PROG_LOW(PROG_LOW_CYC),
    .INIT_TMO(INIT_TMO_CYC)
  ) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start_i),
    .init_s       (init_s),
    .done_s       (done_s),
    .last_bit_done(last_bit_done),
    .post_expired (post_expired),
    .prog_b       (prog_b_o),
    .data_en      (data_en),
    .post_en      (post_en),
    .busy         (busy_o),
    .ok           (ok_o),
    .crc_err      (crc_err_o),
    .timeout      (timeout_o)
  );

  ssc_serializer #(
    .DIV  (CCLK_DIV),
    .EXTRA(DONE_EXTRA),
    .BW   (BYTE_W)
  ) i_ser (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_en      (data_en),
    .post_en      (post_en),
    .byte_data    (cfg_data_i),
    .byte_valid   (cfg_valid_i),
    .byte_last    (cfg_last_i),
    .byte_ready   (cfg_ready_o),
    .cclk         (cclk_o),
    .din          (din_o),
    .last_bit_done(last_bit_done),
    .post_expired (post_expired)
  );

  AST_READY_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready_o |-> (busy_o && prog_b_o && !cclk_o)); // R6

endmodule

// File: tb/test_ssc_loader.sv
module test_ssc_loader;

  localparam int DIV   = 4;
  localparam int HALF  = DIV / 2;
  localparam int PLOW  = 8;
  localparam int ITMO  = 40;
  localparam int EXTRA = 6;
  localparam int DDLY  = 2;   // target raises completion this many bits after the stream
  localparam int CRC_K = 13;  // target reports CRC error at this bit

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] cfg_data = '0;
  logic cfg_valid = 1'b0, cfg_last = 1'b0;
  logic cfg_ready, prog_b, cclk, din, busy, ok, crc_err, tmo;
  logic init_b = 1'b1, done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ssc_loader #(
    .CCLK_DIV(DIV), .PROG_LOW_CYC(PLOW), .INIT_TMO_CYC(ITMO), .DONE_EXTRA(EXTRA), .SYNC_STAGES(2)
  ) i_ssc_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_data_i(cfg_data), .cfg_valid_i(cfg_valid),
    .cfg_last_i(cfg_last), .cfg_ready_o(cfg_ready), .prog_b_o(prog_b), .init_b_i(init_b),
    .cclk_o(cclk), .din_o(din), .done_i(done), .busy_o(busy), .ok_o(ok), .crc_err_o(crc_err),
    .timeout_o(tmo)
  );

  int checks = 0, fails = 0;
  logic [7:0] tx [32];
  logic [7:0] rx [32];

  // target model and monitors (negedge, away from the active edge)
  int tgt_mode = 0, tgt_n = 0;
  int rises, early_rises, din_bad, hi_bad, hi_len, min_gap, last_rise, cyc;
  int prog_falls, low_len, min_low, tcnt, bitn;
  bit init_up, crc_fired, prev_cclk, prev_din, prev_prog;
  logic [7:0] rx_cur;

  task automatic clear_mon();
    rises = 0; early_rises = 0; din_bad = 0; hi_bad = 0; hi_len = 0; min_gap = 1000000;
    last_rise = -1; prog_falls = 0; low_len = 0; min_low = 1000000; bitn = 0; init_up = 1'b0;
    for (int i = 0; i < 32; i++) rx[i] = 8'hxx;
  endtask

  initial begin
    cyc = 0; tcnt = 0; crc_fired = 0; prev_cclk = 0; prev_din = 0; prev_prog = 1; rx_cur = '0;
    clear_mon();
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (prog_b != prev_prog) tcnt = 0; else tcnt++;
        if (!prog_b && prev_prog) prog_falls++;
        if (!prog_b) low_len++;
        if (prog_b && !prev_prog) begin
          if (low_len < min_low) min_low = low_len;
          low_len = 0;
        end
        if (!prog_b) begin
          done = 1'b0; init_up = 1'b0; crc_fired = 1'b0;
          if (tcnt >= 3) init_b = 1'b0;
        end else if (!init_b && tgt_mode != 1 && !crc_fired && tcnt >= 4) begin
          init_b = 1'b1; init_up = 1'b1;
        end
        if (cclk && prev_cclk && din != prev_din) din_bad++;
        if (cclk) hi_len++;
        if (!cclk && prev_cclk) begin
          if (hi_len != HALF && tgt_mode != 2) hi_bad++;
          hi_len = 0;
        end
        if (cclk && !prev_cclk) begin
          rises++;
          if (!init_up) early_rises++;
          if (last_rise >= 0 && (cyc - last_rise) < min_gap) min_gap = cyc - last_rise;
          last_rise = cyc;
          bitn++;
          rx_cur = {rx_cur[6:0], din};
          if (bitn % 8 == 0 && bitn / 8 <= 32) rx[bitn/8 - 1] = rx_cur;
          if (tgt_mode == 2 && bitn == CRC_K) begin init_b = 1'b0; crc_fired = 1'b1; end
          if (tgt_mode == 0 && bitn == 8 * tgt_n + DDLY) done = 1'b1;
        end
      end
      prev_cclk = cclk; prev_din = din; prev_prog = prog_b;
    end
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_rises(input int n, input int mode);
    case (mode)
      0: return 8 * n + DDLY;
      1: return 0;
      2: return CRC_K;
      default: return 8 * n + EXTRA;
    endcase
  endfunction

  task automatic feed(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      bit got;
      if (gaps) repeat ($urandom_range(0, 5)) @(negedge clk);
      if (gaps && i == 2) begin
        int r0;
        repeat (40) @(negedge clk);
        r0 = rises;
        repeat (20) @(negedge clk);
        chk(rises == r0 && !cclk, "R6 clock parked while starved", rises, r0);
        chk(cfg_ready == 1'b1, "R6 ready while starved", cfg_ready, 1);
      end
      cfg_valid = 1'b1; cfg_data = tx[i]; cfg_last = (i == n - 1);
      got = 1'b0;
      while (!got) begin
        if (!busy) begin cfg_valid = 1'b0; return; end
        if (cfg_ready) got = 1'b1;
        @(negedge clk);
      end
      cfg_valid = 1'b0; cfg_last = 1'b0;
    end
  endtask

  task automatic run_cfg(input int n, input int mode, input bit gaps, input bit poke);
    @(posedge clk);
    clear_mon();
    tgt_mode = mode; tgt_n = n;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && !ok && !crc_err && !tmo, "R11 flags cleared and busy on start",
        {busy, ok, crc_err, tmo}, 4'b1000);
    fork
      feed(n, gaps);
      begin
        if (poke) begin
          repeat (70) @(negedge clk);
          start = 1'b1;
          @(negedge clk) start = 1'b0;
        end
      end
    join
    while (busy) @(negedge clk);
  endtask

  task automatic check_good(input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) if (rx[i] !== tx[i]) bad++;
    chk(bad == 0, {"R3 bytes MSB first ", tag}, bad, 0);
    chk(ok && !crc_err && !tmo && !busy, {"R7 success ", tag}, {ok, crc_err, tmo, busy}, 4'b1000);
    chk(rises >= exp_rises(n, 0) && rises <= exp_rises(n, 0) + 1, {"R9 extra clocks ", tag},
        rises, exp_rises(n, 0));
    chk(din_bad == 0, {"R4 din stable in high phase ", tag}, din_bad, 0);
    chk(hi_bad == 0 && min_gap == DIV, {"R5 clock period ", tag}, min_gap, DIV);
    chk(early_rises == 0, {"R2 no clock before init high ", tag}, early_rises, 0);
    chk(min_low >= PLOW && prog_falls == 1, {"R1 strobe width ", tag}, min_low, PLOW);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk(prog_b && !cclk && !cfg_ready && !busy && !ok && !crc_err && !tmo, "R12 reset state",
        {prog_b, cclk, cfg_ready, busy, ok, crc_err, tmo}, 7'b1000000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(prog_b && !busy && !cclk, "R12 idle after reset", {prog_b, busy, cclk}, 3'b100);

    // random bytes with producer gaps
    for (int i = 0; i < 7; i++) tx[i] = 8'($urandom_range(0, 255));
    run_cfg(7, 0, 1'b1, 1'b0);
    check_good(7, "random gapped");

    // R11: flags hold while idle
    repeat (25) @(negedge clk);
    chk(ok && !busy, "R11 flag sticky while idle", ok, 1);

    // directed patterns, back to back
    tx[0] = 8'h00; tx[1] = 8'hFF; tx[2] = 8'h80; tx[3] = 8'h01; tx[4] = 8'hAA; tx[5] = 8'h55;
    run_cfg(6, 0, 1'b0, 1'b0);
    check_good(6, "directed");

    // single byte boundary, plus a start poked mid-load (R10)
    tx[0] = 8'hC3;
    run_cfg(1, 0, 1'b0, 1'b0);
    check_good(1, "single byte");
    for (int i = 0; i < 8; i++) tx[i] = 8'($urandom_range(0, 255));
    run_cfg(8, 0, 1'b0, 1'b1);
    chk(prog_falls == 1, "R10 start ignored while busy", prog_falls, 1);
    check_good(8, "start poked");

    // CRC error in data phase
    for (int i = 0; i < 6; i++) tx[i] = 8'($urandom_range(0, 255));
    run_cfg(6, 2, 1'b0, 1'b0);
    chk(crc_err && !ok && !tmo && !busy, "R8 crc flagged", {crc_err, ok, tmo, busy}, 4'b1000);
    chk(rises >= CRC_K && rises <= CRC_K + 1, "R8 clock stops after crc", rises, CRC_K);

    // init never released
    run_cfg(3, 1, 1'b0, 1'b0);
    chk(tmo && !ok && !crc_err, "R2 init timeout flag", {tmo, ok, crc_err}, 3'b100);
    chk(rises == exp_rises(3, 1), "R2 no clock without init", rises, 0);

    // completion never seen
    for (int i = 0; i < 4; i++) tx[i] = 8'($urandom_range(0, 255));
    run_cfg(4, 3, 1'b1, 1'b0);
    chk(tmo && !ok && !crc_err, "R9 done timeout flag", {tmo, ok, crc_err}, 3'b100);
    chk(rises == exp_rises(4, 3), "R9 exact extra clocks", rises, exp_rises(4, 3));
    begin
      int bad = 0;
      for (int i = 0; i < 4; i++) if (rx[i] !== tx[i]) bad++;
      chk(bad == 0, "R3 bytes before done timeout", bad, 0);
    end

    // recovery after error: clean run clears timeout
    for (int i = 0; i < 5; i++) tx[i] = 8'($urandom_range(0, 255));
    run_cfg(5, 0, 1'b1, 1'b0);
    check_good(5, "after timeout");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule